// File: doc/BRIEF.md
# Transmit Byte Queue with Link-Loss Drain

This block is a byte-wide first-in first-out queue between a system-side producer and the transmit MAC. The producer writes one byte per clock while the full flag is low. The MAC takes bytes through a valid/ready handshake, and the head byte is visible on the read data port in the same cycle that valid is high. The link counts as up only when the receiver reports symbol synchronization and auto-negotiation has completed. While the link is down the MAC side takes nothing, because the line is busy sending idle or configuration code groups.

With the drain mode enable low, a down link simply holds the queue. The producer can keep writing until the queue is full; writes after that are dropped and raise a sticky overflow flag. With the drain mode enable high, a down link makes the queue discard its head entry on every clock in which it holds data, so the queue keeps emptying and cannot overflow. When the link returns, forwarding resumes on the next clock from whatever is still queued. A packet that was partly discarded is not repaired. Everything runs on one clock.

Top module: `txq_flush_fifo`

## Requirements
- R1: After reset the queue is empty: `rd_valid` = 0, `wr_full` = 0 and `ovf_sticky` = 0.
- R2: While the link is up, bytes appear on `rd_data` in the order they were written. The head entry is removed on a clock edge where `rd_valid` and `rd_ready` are both 1.
- R3: `wr_full` is 1 exactly when the queue holds DEPTH entries (64 by default). A write while `wr_full` is 1 stores nothing, and that byte never appears on `rd_data`.
- R4: `ovf_sticky` becomes 1 on the clock after a write attempt while `wr_full` is 1. It stays 1 until an `ovf_clr` pulse clears it on the next edge. A new overflow in the same cycle as `ovf_clr` takes priority, so the flag stays set.
- R5: The link is up only when `rx_sync_ok` = 1 and `an_done` = 1. Whenever the link is down, `rd_valid` is 0 whatever the queue holds.
- R6: Link down with `flush_en` = 0: no entry leaves the queue. After the link returns, every held byte comes out in order.
- R7: Link down with `flush_en` = 1: one entry is discarded per clock while the queue is not empty, including bytes written during that time. After as many cycles as there were entries, `wr_full` is 0. When the link returns, `rd_valid` is 0 at once.
- R8: After a partial drain, the clock on which the link returns shows the oldest surviving byte on `rd_data` with `rd_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the system side |
| wr_data | input | DATA_W | Byte to enqueue |
| wr_full | output | 1 | Queue holds DEPTH entries |
| rd_data | output | DATA_W | Head byte toward the MAC |
| rd_valid | output | 1 | Head byte is offered to the MAC |
| rd_ready | input | 1 | MAC accepts the head byte |
| rx_sync_ok | input | 1 | Receiver has symbol synchronization |
| an_done | input | 1 | Auto-negotiation has completed |
| flush_en | input | 1 | Configuration bit: discard output while the link is down |
| ovf_clr | input | 1 | Pulse that clears the overflow flag |
| ovf_sticky | output | 1 | A write was dropped because the queue was full |

## Verification
Each of the three link modes is tried: forwarding, holding, and draining. The drain enable is set and cleared independently of the two link inputs, so a design that keys the drain off only one of them stands out. Random writes, random back-pressure and toggling link inputs run against a queue model, which separates correct ordering from duplicated or skipped entries. The directed cases cover a full queue with an extra write, a clear pulse, a complete drain followed by link return, and a partial drain. Together they show whether dropped bytes leak out and whether forwarding restarts from the right entry.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef enum logic [1:0] {
      TXQ_FORWARD = 2'd0,
      TXQ_HOLD    = 2'd1,
      TXQ_DRAIN   = 2'd2
   } txq_mode_e;
endpackage

// File: rtl/txq_link_mon.sv
module txq_link_mon
   import txq_pkg::*;
(
   input  logic      rx_sync_ok,
   input  logic      an_done,
   input  logic      flush_en,
   output txq_mode_e mode
);
   always_comb begin
      if (rx_sync_ok && an_done) mode = TXQ_FORWARD;
      else if (flush_en)         mode = TXQ_DRAIN;
      else                       mode = TXQ_HOLD;
   end
endmodule

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic [CW-1:0]     fill_cnt,
   output logic              empty,
   output logic              full
);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         fill_cnt <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         fill_cnt <= fill_cnt + CW'(push) - CW'(pop);
      end
   end

   assign head_data = mem[rd_ptr];
   assign empty     = (fill_cnt == '0);
   assign full      = (fill_cnt == CW'(DEPTH));
endmodule

// File: rtl/txq_ovf_flag.sv
module txq_ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/txq_flush_fifo.sv
module txq_flush_fifo
   import txq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   input  logic              rx_sync_ok,
   input  logic              an_done,
   input  logic              flush_en,
   input  logic              ovf_clr,
   output logic              ovf_sticky
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("txq_flush_fifo: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("txq_flush_fifo: DEPTH must be at least 2");
      end
   endgenerate

   txq_mode_e   mode;
   logic        drain, fwd, empty, push, pop;
   logic [CW-1:0] fill_cnt;

   txq_link_mon u_link (
      .rx_sync_ok (rx_sync_ok),
      .an_done    (an_done),
      .flush_en   (flush_en),
      .mode       (mode)
   );

   assign fwd      = (mode == TXQ_FORWARD);
   assign drain    = (mode == TXQ_DRAIN);
   assign rd_valid = fwd && !empty;
   assign pop      = (rd_valid && rd_ready) || (drain && !empty);
   assign push     = wr_en && !wr_full;

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (wr_data),
      .pop       (pop),
      .head_data (rd_data),
      .fill_cnt  (fill_cnt),
      .empty     (empty),
      .full      (wr_full)
   );

   txq_ovf_flag u_ovf (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wr_en && wr_full),
      .clr_i  (ovf_clr),
      .flag_o (ovf_sticky)
   );
endmodule

// File: rtl/txq_flush_fifo_chk.sv
module txq_flush_fifo_chk #(
   parameter int DEPTH = 64,
   parameter int CW    = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          wr_full,
   input logic          rd_valid,
   input logic          rx_sync_ok,
   input logic          an_done,
   input logic          flush_en,
   input logic          ovf_clr,
   input logic          ovf_sticky,
   input logic [CW-1:0] fill_cnt
);
   assert_link_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_sync_ok && an_done) |-> !rd_valid);

   assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_full) |=> ovf_sticky);

   assert_ovf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sticky && !ovf_clr) |=> ovf_sticky);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CW'(DEPTH));

   assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rx_sync_ok && an_done) && !flush_en && !wr_en) |=> $stable(fill_cnt));

   assert_drain_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rx_sync_ok && an_done) && flush_en && !wr_en && fill_cnt != '0)
      |=> fill_cnt == $past(fill_cnt) - 1'b1);
endmodule

bind txq_flush_fifo txq_flush_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_full    (wr_full),
   .rd_valid   (rd_valid),
   .rx_sync_ok (rx_sync_ok),
   .an_done    (an_done),
   .flush_en   (flush_en),
   .ovf_clr    (ovf_clr),
   .ovf_sticky (ovf_sticky),
   .fill_cnt   (fill_cnt)
);

// File: tb/txq_flush_fifo_test.sv
module txq_flush_fifo_test;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int DEPTH      = 64;
   localparam int SEED       = 1234;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              wr_full;
   logic [DATA_W-1:0] rd_data;
   logic              rd_valid;
   logic              rd_ready = 1'b0;
   logic              rx_sync_ok = 1'b0;
   logic              an_done = 1'b0;
   logic              flush_en = 1'b0;
   logic              ovf_clr = 1'b0;
   logic              ovf_sticky;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DATA_W-1:0] q[$];
   bit m_ovf = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txq_flush_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rx_sync_ok(rx_sync_ok), .an_done(an_done),
      .flush_en(flush_en), .ovf_clr(ovf_clr), .ovf_sticky(ovf_sticky)
   );

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit link_up_f(bit s, bit a);
      return s && a;
   endfunction

   function automatic bit pop_f(bit lu, bit fe, bit rdy, int n);
      return (n != 0) && ((lu && rdy) || (!lu && fe));
   endfunction

   // called at a negative edge with inputs set; checks, updates model, advances one cycle
   task automatic step();
      bit lu, ev, fu, pp;
      #1;
      lu = link_up_f(rx_sync_ok, an_done);
      fu = (q.size() == DEPTH);
      ev = lu && (q.size() != 0);
      check(rd_valid == ev, "R5 rd_valid", int'(rd_valid), int'(ev));
      if (ev) check(rd_data == q[0], "R2 rd_data order", int'(rd_data), int'(q[0]));
      check(wr_full == fu, "R3 wr_full", int'(wr_full), int'(fu));
      check(ovf_sticky == m_ovf, "R4 ovf_sticky", int'(ovf_sticky), int'(m_ovf));
      pp = pop_f(lu, flush_en, rd_ready, q.size());
      m_ovf = (wr_en && fu) ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
      if (pp) void'(q.pop_front());
      if (wr_en && !fu) q.push_back(wr_data);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; rd_ready = 1'b0; ovf_clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(SEED);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      check(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
      check(wr_full == 1'b0, "R1 wr_full after reset", int'(wr_full), 0);
      check(ovf_sticky == 1'b0, "R1 ovf after reset", int'(ovf_sticky), 0);
      @(negedge clk);

      // R6 and R3/R4: hold mode, fill to full, extra write
      rx_sync_ok = 1'b1; an_done = 1'b0; flush_en = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         wr_en = 1'b1; wr_data = DATA_W'(i + 1);
         step();
      end
      wr_en = 1'b1; wr_data = 8'hEE;
      #1; check(wr_full == 1'b1, "R3 full at DEPTH", int'(wr_full), 1);
      step();
      wr_en = 1'b0;
      #1; check(ovf_sticky == 1'b1, "R4 ovf set on dropped write", int'(ovf_sticky), 1);
      step();
      ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
      #1; check(ovf_sticky == 1'b0, "R4 ovf cleared by pulse", int'(ovf_sticky), 0);
      // same-cycle overflow and clear: overflow wins (queue still full)
      wr_en = 1'b1; ovf_clr = 1'b1; wr_data = 8'hEE; step();
      wr_en = 1'b0; ovf_clr = 1'b0;
      #1; check(ovf_sticky == 1'b1, "R4 set beats clear", int'(ovf_sticky), 1);
      ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
      // R5: sync alone is not link up
      #1; check(rd_valid == 1'b0, "R5 an_done low gates valid", int'(rd_valid), 0);
      // link up: drain all in order
      an_done = 1'b1; rd_ready = 1'b1;
      #1; check(rd_valid == 1'b1 && rd_data == 8'd1, "R6 first held byte", int'(rd_data), 1);
      for (int i = 0; i < DEPTH; i++) step();
      #1; check(rd_valid == 1'b0, "R3 dropped byte never read", int'(rd_valid), 0);
      idle_inputs();

      // R7: full drain
      for (int i = 0; i < 20; i++) begin
         wr_en = 1'b1; wr_data = DATA_W'(8'h40 + i); step();
      end
      wr_en = 1'b0; rx_sync_ok = 1'b0; flush_en = 1'b1;
      for (int i = 0; i < 20; i++) step();
      rx_sync_ok = 1'b1;
      #1; check(rd_valid == 1'b0, "R7 empty after drain", int'(rd_valid), 0);
      check(wr_full == 1'b0, "R7 not full after drain", int'(wr_full), 0);
      step();

      // R8: partial drain then resume
      for (int i = 0; i < 10; i++) begin
         wr_en = 1'b1; wr_data = DATA_W'(8'h80 + i); step();
      end
      wr_en = 1'b0; an_done = 1'b0;
      for (int i = 0; i < 4; i++) step();
      an_done = 1'b1; rd_ready = 1'b0;
      #1; check(rd_valid == 1'b1 && rd_data == 8'h84, "R8 resume at oldest survivor",
                int'(rd_data), 8'h84);
      rd_ready = 1'b1;
      for (int i = 0; i < 6; i++) step();
      idle_inputs();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         wr_en      = ($urandom % 4) != 0;
         wr_data    = DATA_W'($urandom);
         rd_ready   = ($urandom % 3) != 0;
         rx_sync_ok = ($urandom % 8) != 0;
         an_done    = ($urandom % 8) != 0;
         if (($urandom % 64) == 0) flush_en = ~flush_en;
         ovf_clr    = ($urandom % 32) == 0;
         step();
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule